// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides the operating mode of one digital PLL. Its inputs are a qualified flag for each candidate reference, a phase-lock indication from the loop, and a manual override made of an enable and a requested mode. From these it runs the PLL through four modes: free-run, lock acquisition, normal (locked) and holdover. The loop filter, the phase detector and the reference quality monitors sit outside the block and report to it over single-bit inputs.

The controller owns the choice of reference. Whenever it enters acquisition on a reference it picks the lowest-numbered qualified one. It then raises a one-cycle switch strobe and presents that reference's index, which stays on `ref_sel` until the next switch. Holdover is entered only when the selected reference fails and no other reference is qualified. If another qualified reference exists, the controller starts acquisition on it instead. All pins are plain control and status levels. No streaming interface is involved, so there is no back-pressure.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (encoding: 0 free-run, 1 acquisition, 2 normal, 3 holdover), `locked`, `holdover` and `sw_req` are low, and `ref_sel` is 0.
- R2: In automatic operation (`man_en` low), free-run persists while no bit of `ref_ok` is set.
- R3: In automatic free-run, if any `ref_ok` bit is set at a clock edge, the next cycle shows mode 1, `ref_sel` equal to the lowest set bit index, and `sw_req` high.
- R4: In automatic acquisition, if `lock_ind` is high and the selected reference is still qualified, the next mode is 2.
- R5: In automatic acquisition or normal mode, if the selected reference loses qualification while another is qualified, the next mode is 1, on the lowest-numbered other qualified reference, with `sw_req` high.
- R6: In automatic normal mode, if the selected reference loses qualification and no reference is qualified, the next mode is 3.
- R7: In automatic holdover, if any reference becomes qualified, the next mode is 1 on the lowest qualified index, with `sw_req` high.
- R8: In automatic acquisition, if the selected reference is lost and none is qualified, the next mode is 3 if mode 2 has been reached since reset, and 0 otherwise.
- R9: With `man_en` high, the next mode equals `man_mode`. A request for mode 1 while no reference is qualified leaves the mode unchanged. A request for mode 1 from another mode selects the lowest qualified index and pulses `sw_req`. `lock_ind` has no effect while `man_en` is high.
- R10: `locked` is high exactly when the mode is 2, and `holdover` is high exactly when the mode is 3.
- R11: `sw_req` is high for one cycle per switch only, and `ref_sel` changes only in a cycle where `sw_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | NUM_REFS | Per-reference qualified flags |
| lock_ind | input | 1 | Phase lock reported by the loop |
| man_en | input | 1 | Manual mode override enable |
| man_mode | input | 2 | Requested mode when manual |
| mode | output | 2 | Current operating mode |
| locked | output | 1 | High in normal mode |
| holdover | output | 1 | High in holdover |
| sw_req | output | 1 | One-cycle reference switch strobe |
| ref_sel | output | $clog2(NUM_REFS) | Index of the selected reference |

## Verification
The bench checks that losing the reference during acquisition ends in free-run before any lock has been reached and in holdover after one. A design that forgot its lock history would pick the wrong one of these two modes. It drops the selected reference while a lower- or higher-numbered one stays qualified, which would expose a controller that fell into holdover or reselected the failed index. It also sends manual acquisition requests with no qualified reference, and it holds `lock_ind` high under manual control, where a faulty design would move to an unqualified reference or drift into normal mode. Randomised stretches then catch strobes that last too long or selections that change without a strobe.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_NORM = 2'd2,
    MODE_HOLD = 2'd3
  } dpll_mode_e;
endpackage

// File: rtl/dpll_lowest_pick.sv
module dpll_lowest_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dpll_ref_mask.sv
module dpll_ref_mask #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  ok,
  input  logic [IW-1:0] sel,
  output logic [N-1:0]  others,
  output logic          sel_ok
);
  for (genvar g = 0; g < N; g++) begin : g_mask
    assign others[g] = ok[g] & (sel != IW'(g));
  end
  assign sel_ok = |(ok & ~others);
endmodule

// File: rtl/dpll_mode_next.sv
module dpll_mode_next
  import dpll_mode_pkg::*;
#(
  parameter int IW = 3
) (
  input  dpll_mode_e    cur_mode,
  input  logic [IW-1:0] cur_sel,
  input  logic          ever_locked,
  input  logic          sel_ok,
  input  logic          any_ok,
  input  logic [IW-1:0] low_ok,
  input  logic          any_oth,
  input  logic [IW-1:0] low_oth,
  input  logic          lock_ind,
  input  logic          man_en,
  input  logic [1:0]    man_mode,
  output dpll_mode_e    nxt_mode,
  output logic [IW-1:0] nxt_sel,
  output logic          nxt_sw
);
  always_comb begin
    nxt_mode = cur_mode;
    nxt_sel  = cur_sel;
    nxt_sw   = 1'b0;
    if (man_en) begin
      if (dpll_mode_e'(man_mode) == MODE_ACQ) begin
        if (cur_mode != MODE_ACQ && any_ok) begin
          nxt_mode = MODE_ACQ;
          nxt_sel  = low_ok;
          nxt_sw   = 1'b1;
        end
      end else begin
        nxt_mode = dpll_mode_e'(man_mode);
      end
    end else begin
      unique case (cur_mode)
        MODE_FREE, MODE_HOLD: begin
          if (any_ok) begin
            nxt_mode = MODE_ACQ;
            nxt_sel  = low_ok;
            nxt_sw   = 1'b1;
          end
        end
        MODE_ACQ: begin
          if (!sel_ok) begin
            if (any_oth) begin
              nxt_sel = low_oth;
              nxt_sw  = 1'b1;
            end else begin
              nxt_mode = ever_locked ? MODE_HOLD : MODE_FREE;
            end
          end else if (lock_ind) begin
            nxt_mode = MODE_NORM;
          end
        end
        MODE_NORM: begin
          if (!sel_ok) begin
            if (any_oth) begin
              nxt_mode = MODE_ACQ;
              nxt_sel  = low_oth;
              nxt_sw   = 1'b1;
            end else begin
              nxt_mode = MODE_HOLD;
            end
          end
        end
        default: nxt_mode = MODE_FREE;
      endcase
    end
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int NUM_REFS = 8,
  localparam int IW = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REFS-1:0] ref_ok,
  input  logic                lock_ind,
  input  logic                man_en,
  input  logic [1:0]          man_mode,
  output logic [1:0]          mode,
  output logic                locked,
  output logic                holdover,
  output logic                sw_req,
  output logic [IW-1:0]       ref_sel
);
  dpll_mode_e    mode_q, mode_d;
  logic [IW-1:0] sel_q, sel_d;
  logic          sw_q, sw_d;
  logic          had_q;

  logic [NUM_REFS-1:0] oth_ok;
  logic                sel_ok, any_ok, any_oth;
  logic [IW-1:0]       low_ok, low_oth;

  dpll_ref_mask #(.N(NUM_REFS), .IW(IW)) u_mask (
    .ok(ref_ok), .sel(sel_q), .others(oth_ok), .sel_ok(sel_ok)
  );

  dpll_lowest_pick #(.N(NUM_REFS), .IW(IW)) u_pick_all (
    .req(ref_ok), .found(any_ok), .idx(low_ok)
  );

  dpll_lowest_pick #(.N(NUM_REFS), .IW(IW)) u_pick_oth (
    .req(oth_ok), .found(any_oth), .idx(low_oth)
  );

  dpll_mode_next #(.IW(IW)) u_next (
    .cur_mode(mode_q), .cur_sel(sel_q), .ever_locked(had_q),
    .sel_ok(sel_ok), .any_ok(any_ok), .low_ok(low_ok),
    .any_oth(any_oth), .low_oth(low_oth), .lock_ind(lock_ind),
    .man_en(man_en), .man_mode(man_mode),
    .nxt_mode(mode_d), .nxt_sel(sel_d), .nxt_sw(sw_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      sel_q  <= '0;
      sw_q   <= 1'b0;
      had_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      sw_q   <= sw_d;
      if (mode_d == MODE_NORM) had_q <= 1'b1;
    end
  end

  assign mode     = mode_q;
  assign locked   = (mode_q == MODE_NORM);
  assign holdover = (mode_q == MODE_HOLD);
  assign sw_req   = sw_q;
  assign ref_sel  = sel_q;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
  parameter int NUM_REFS = 8,
  localparam int IW = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_REFS-1:0] ref_ok,
  input logic                lock_ind,
  input logic                man_en,
  input logic [1:0]          man_mode,
  input logic [1:0]          mode,
  input logic                locked,
  input logic                holdover,
  input logic                sw_req,
  input logic [IW-1:0]       ref_sel
);
  logic sel_q_ok;
  assign sel_q_ok = ((ref_ok >> ref_sel) & NUM_REFS'(1)) != '0;

  assert_free_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode == 2'd0 && ref_ok == '0) |=> (mode == 2'd0));

  assert_free_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode == 2'd0 && ref_ok != '0) |=> (mode == 2'd1 && sw_req));

  assert_acq_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode == 2'd1 && lock_ind && sel_q_ok) |=> (mode == 2'd2));

  assert_norm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode == 2'd2 && ref_ok == '0) |=> (mode == 2'd3));

  assert_hold_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode == 2'd3 && ref_ok != '0) |=> (mode == 2'd1 && sw_req));

  assert_manual_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (man_en && man_mode != 2'd1) |=> (mode == $past(man_mode)));

  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked == (mode == 2'd2)) && (holdover == (mode == 2'd3)));

  assert_switch_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> ((($past(ref_ok) >> ref_sel) & NUM_REFS'(1)) != '0));

  assert_sel_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |-> $stable(ref_sel));
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.NUM_REFS(NUM_REFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_ind(lock_ind),
  .man_en(man_en), .man_mode(man_mode), .mode(mode), .locked(locked),
  .holdover(holdover), .sw_req(sw_req), .ref_sel(ref_sel)
);

// File: tb/tb_dpll_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dpll_mode_ctrl;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ref_ok;
  logic          lock_ind, man_en;
  logic [1:0]    man_mode;
  logic [1:0]    mode;
  logic          locked, holdover, sw_req;
  logic [IW-1:0] ref_sel;

  int checks = 0;
  int fails  = 0;
  int m_mode, m_sel, m_sw, m_had;
  string tag;

  always #2.5 clk = ~clk;

  dpll_mode_ctrl #(.NUM_REFS(N)) dut (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_ind(lock_ind),
    .man_en(man_en), .man_mode(man_mode), .mode(mode), .locked(locked),
    .holdover(holdover), .sw_req(sw_req), .ref_sel(ref_sel)
  );

  function automatic int lowest(input logic [N-1:0] v, input int skip);
    for (int i = 0; i < N; i++) if (v[i] && i != skip) return i;
    return -1;
  endfunction

  task automatic model_step();
    int lo;
    m_sw = 0;
    if (man_en) begin
      if (man_mode == 2'd1) begin
        lo = lowest(ref_ok, -1);
        if (m_mode != 1 && lo >= 0) begin m_mode = 1; m_sel = lo; m_sw = 1; end
      end else m_mode = int'(man_mode);
    end else begin
      case (m_mode)
        0, 3: begin
          lo = lowest(ref_ok, -1);
          if (lo >= 0) begin m_mode = 1; m_sel = lo; m_sw = 1; end
        end
        1: begin
          if (!ref_ok[m_sel]) begin
            lo = lowest(ref_ok, m_sel);
            if (lo >= 0) begin m_sel = lo; m_sw = 1; end
            else m_mode = m_had ? 3 : 0;
          end else if (lock_ind) m_mode = 2;
        end
        default: begin
          if (!ref_ok[m_sel]) begin
            lo = lowest(ref_ok, m_sel);
            if (lo >= 0) begin m_mode = 1; m_sel = lo; m_sw = 1; end
            else m_mode = 3;
          end
        end
      endcase
    end
    if (m_mode == 2) m_had = 1;
  endtask

  task automatic compare();
    logic [7:0] act, exp;
    act = {mode, locked, holdover, sw_req, ref_sel};
    exp = {2'(m_mode), m_mode == 2, m_mode == 3, m_sw[0], 3'(m_sel)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mode,lock,hold,sw,sel} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] ok, input logic lk, input logic me,
                     input logic [1:0] mm, input string t);
    @(negedge clk);
    ref_ok = ok; lock_ind = lk; man_en = me; man_mode = mm; tag = t;
    @(posedge clk);
    model_step();
    #1 compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_ok = '0; lock_ind = 1'b0; man_en = 1'b0; man_mode = 2'd0;
    m_mode = 0; m_sel = 0; m_sw = 0; m_had = 0; tag = "R1";
    repeat (3) @(posedge clk);
    #1 compare();                               // R1 reset state
    @(negedge clk) rst_n = 1'b1;
    repeat (3) cyc(8'h00, 1'b1, 1'b0, 2'd0, "R2");
    cyc(8'h28, 1'b0, 1'b0, 2'd0, "R3");          // lowest is 3
    cyc(8'h28, 1'b0, 1'b0, 2'd0, "R11");
    cyc(8'h20, 1'b0, 1'b0, 2'd0, "R5");          // acq: move to 5
    cyc(8'h00, 1'b0, 1'b0, 2'd0, "R8");          // never locked -> free
    cyc(8'h01, 1'b0, 1'b0, 2'd0, "R3");
    cyc(8'h01, 1'b1, 1'b0, 2'd0, "R4");
    cyc(8'h81, 1'b1, 1'b0, 2'd0, "R10");
    cyc(8'h80, 1'b1, 1'b0, 2'd0, "R5");          // normal: move to 7
    cyc(8'h80, 1'b1, 1'b0, 2'd0, "R4");
    cyc(8'h00, 1'b0, 1'b0, 2'd0, "R6");
    cyc(8'h00, 1'b0, 1'b0, 2'd0, "R10");
    cyc(8'h04, 1'b0, 1'b0, 2'd0, "R7");
    cyc(8'h00, 1'b0, 1'b0, 2'd0, "R8");          // locked before -> hold
    cyc(8'h00, 1'b0, 1'b1, 2'd0, "R9");
    cyc(8'h00, 1'b1, 1'b1, 2'd1, "R9");          // no ref: unchanged
    cyc(8'h10, 1'b1, 1'b1, 2'd1, "R9");          // acq on 4
    cyc(8'h10, 1'b1, 1'b1, 2'd1, "R9");          // lock ignored
    cyc(8'h10, 1'b0, 1'b1, 2'd2, "R9");
    cyc(8'h00, 1'b0, 1'b1, 2'd3, "R9");
    cyc(8'h10, 1'b0, 1'b0, 2'd0, "R7");
    for (int k = 0; k < 2000; k++) begin
      logic [N-1:0] rv;
      rv = N'($urandom);
      if ($urandom_range(0, 2) != 0) rv = rv & N'($urandom);
      cyc(rv, 1'($urandom), ($urandom_range(0, 7) == 0), 2'($urandom), "R11");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule